// File: doc/BRIEF.md
# PCIe Lane Split Mode Latch

This block decides, on the device side, whether a four-lane PCIe link is presented as a single x4 port or as two independent x2 ports. The host selects the mode with an active-low select input. Inside the device that input is pulled high, so an undriven select means one x4 port and a select driven low means two x2 ports. Each port has its own active-low reset from the host: port A and port B.

The select is meant to be static. The block measures how long the select has been held steady using a cycle counter. The counter's limit is derived from the clock frequency and a minimum hold time, which defaults to 1000 ns. While both port resets are held, a steady select is adopted as the lane mode. Once either port leaves reset, the mode is frozen. A port released too early or a select that moves while the mode is frozen raises a sticky fault, and the mode already latched is kept.

The block reports the mode, one enable per port and the fault. It also drives a constant serial-attach indicator that is low, which marks the drive as PCIe rather than SAS/SATA. The port resets and the select pass through two-flop synchronisers before any use.

Top module: `portsplit_cfg`

## Requirements
- R1: While and after power-on reset (`rst_n` low), `lane_dual` is 0 (single x4 port), `port_a_en` and `port_b_en` are 0, and `mode_fault` is 0.
- R2: With `dual_sel_n` high (undriven), the adopted mode is single x4 (`lane_dual` = 0). Only port A is enabled. Releasing `port_b_rst_n` never sets `port_b_en`.
- R3: With `dual_sel_n` low, the adopted mode is dual x2 (`lane_dual` = 1). `port_a_en` follows the release of `port_a_rst_n` and `port_b_en` follows the release of `port_b_rst_n`, each on its own.
- R4: While both resets are held low, a new `dual_sel_n` level reaches `lane_dual` only after it has stayed unchanged for HOLD = ceil(CLK_MHZ*HOLD_NS/1000) cycles. Any change restarts the count.
- R5: While either port reset is high, `lane_dual` does not change. Mode changes made while both resets are low raise no fault.
- R6: If a port reset is released before the select has been stable for HOLD cycles, `mode_fault` goes to 1 and `lane_dual` keeps its previous value.
- R7: If `dual_sel_n` changes while either port is out of reset, `mode_fault` goes to 1 and `lane_dual` keeps its value.
- R8: `mode_fault` stays 1 until the next power-on reset, including across later port reset cycles.
- R9: `serial_iface` is constantly 0, which identifies the interface as PCIe.
- R10: Port resets are synchronised with two flops. A port enable rises on the third clock edge after its reset input is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| dual_sel_n | input | 1 | Lane split select, active low (low = two x2 ports) |
| port_a_rst_n | input | 1 | Port A reset from host, active low |
| port_b_rst_n | input | 1 | Port B reset from host, active low |
| lane_dual | output | 1 | Latched mode: 0 = one x4 port, 1 = two x2 ports |
| port_a_en | output | 1 | Port A out of reset and in use |
| port_b_en | output | 1 | Port B out of reset and in use (dual mode only) |
| mode_fault | output | 1 | Sticky timing or mode-change violation |
| serial_iface | output | 1 | Constant 0: interface is PCIe, not SAS/SATA |

## Verification
The bench builds the block with CLK_MHZ = 20 and HOLD_NS = 1000, which gives a hold window of 20 cycles. With that short window, releases well inside and well outside the window can both be tested in a few hundred cycles. The same setting lets the mode be watched half way through the window and just after it, and a power-on reset pulse between sticky-fault scenarios stays cheap. The default of 100 MHz only widens the counter.

// File: rtl/portsplit_pkg.sv
package portsplit_pkg;

  typedef enum logic {
    LANES_X4   = 1'b0,
    LANES_X2X2 = 1'b1
  } lane_mode_e;

  // Cycles covering ns nanoseconds at mhz MHz, rounded up.
  function automatic int unsigned hold_cycles(int unsigned mhz, int unsigned ns);
    return (mhz * ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/portsplit_sync.sv
module portsplit_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[gi];
        s2 <= RST_VAL[gi];
      end else begin
        s1 <= d[gi];
        s2 <= s1;
      end
    end
    assign q[gi] = s2;
  end
endmodule

// File: rtl/portsplit_hold_timer.sv
module portsplit_hold_timer #(
  parameter int unsigned HOLD = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic chg,
  output logic stable_ok
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  assign chg       = (sel_n != prev_q);
  assign stable_ok = (cnt_q == LIMIT) && !chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= sel_n;
      if (chg)                cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: a change of the select restarts the window
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (cnt_q == '0));
  // R4: the count saturates at the window length
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/portsplit_mode_lock.sv
module portsplit_mode_lock
  import portsplit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic a_up,
  input  logic b_up,
  input  logic chg,
  input  logic stable_ok,
  output logic lane_dual,
  output logic pa_en,
  output logic pb_en,
  output logic fault
);
  lane_mode_e mode_q, mode_d;
  logic locked, locked_q, rel, accept, fault_evt;
  logic pa_q, pb_q, fault_q;

  assign locked    = a_up || b_up;
  assign rel       = locked && !locked_q;
  assign accept    = stable_ok && !locked_q;
  assign mode_d    = accept ? (sel_n ? LANES_X4 : LANES_X2X2) : mode_q;
  assign fault_evt = (rel && !stable_ok) || (locked_q && chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= LANES_X4;
      locked_q <= 1'b0;
      pa_q     <= 1'b0;
      pb_q     <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      locked_q <= locked;
      pa_q     <= a_up;
      pb_q     <= b_up && (mode_d == LANES_X2X2);
      fault_q  <= fault_q || fault_evt;
    end
  end

  assign lane_dual = (mode_q == LANES_X2X2);
  assign pa_en     = pa_q;
  assign pb_en     = pb_q;
  assign fault     = fault_q;

  // R5: mode frozen while a port is out of reset
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_q));
  // R2: port B never enabled in single-port mode
  a_r2_b_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LANES_X4) |-> !pb_q);
  // R6: early release flags a fault
  a_r6_early: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !stable_ok) |=> fault_q);
  // R7: select moving while locked flags a fault
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && chg) |=> fault_q);
  // R8: fault is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);
endmodule

// File: rtl/portsplit_cfg.sv
module portsplit_cfg
  import portsplit_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned HOLD_NS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_sel_n,
  input  logic port_a_rst_n,
  input  logic port_b_rst_n,
  output logic lane_dual,
  output logic port_a_en,
  output logic port_b_en,
  output logic mode_fault,
  output logic serial_iface
);
  localparam int unsigned HOLD = hold_cycles(CLK_MHZ, HOLD_NS);

  logic [2:0] raw, synced;
  logic chg, stable_ok;

  assign raw = {dual_sel_n, port_b_rst_n, port_a_rst_n};

  portsplit_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  portsplit_hold_timer #(.HOLD(HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .sel_n(synced[2]),
    .chg(chg), .stable_ok(stable_ok)
  );

  portsplit_mode_lock u_lock (
    .clk(clk), .rst_n(rst_n), .sel_n(synced[2]),
    .a_up(synced[0]), .b_up(synced[1]),
    .chg(chg), .stable_ok(stable_ok),
    .lane_dual(lane_dual), .pa_en(port_a_en), .pb_en(port_b_en),
    .fault(mode_fault)
  );

  assign serial_iface = 1'b0;

  // R9: interface type never reports serial attach
  a_r9_pcie: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_iface);
endmodule

// File: tb/test_portsplit_cfg.sv
module test_portsplit_cfg;
  localparam int unsigned MHZ = 20;
  localparam int unsigned NS  = 1000;
  localparam int unsigned S   = (MHZ * NS + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_sel_n = 1'b1;
  logic port_a_rst_n = 1'b0;
  logic port_b_rst_n = 1'b0;
  logic lane_dual, port_a_en, port_b_en, mode_fault, serial_iface;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  portsplit_cfg #(.CLK_MHZ(MHZ), .HOLD_NS(NS)) i_portsplit_cfg (
    .clk(clk), .rst_n(rst_n), .dual_sel_n(dual_sel_n),
    .port_a_rst_n(port_a_rst_n), .port_b_rst_n(port_b_rst_n),
    .lane_dual(lane_dual), .port_a_en(port_a_en), .port_b_en(port_b_en),
    .mode_fault(mode_fault), .serial_iface(serial_iface)
  );

  // {sel_n, release A, release B, exp dual, exp A en, exp B en}
  localparam logic [5:0] VEC [6] = '{
    6'b111_010,   // R2 single, B reset ignored
    6'b011_111,   // R3 dual, both ports
    6'b001_101,   // R3 dual, B alone
    6'b101_000,   // R2 single, only B released
    6'b010_110,   // R3 dual, A alone
    6'b110_010    // R2 single, A alone
  };

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    chk("R1 mode", lane_dual, 1'b0);
    chk("R1 a_en", port_a_en, 1'b0);
    chk("R1 b_en", port_b_en, 1'b0);
    chk("R1 fault", mode_fault, 1'b0);
    chk("R9 serial", serial_iface, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      logic [5:0] v;
      v = VEC[i];
      dual_sel_n = v[5];
      cyc(S + 6);
      chk("R4 mode while held", lane_dual, v[2]);
      port_a_rst_n = v[4];
      port_b_rst_n = v[3];
      cyc(6);
      chk("R2/R3 mode", lane_dual, v[2]);
      chk("R2/R3 a_en", port_a_en, v[1]);
      chk("R2/R3 b_en", port_b_en, v[0]);
      chk("R5 no fault", mode_fault, 1'b0);
      port_a_rst_n = 1'b0;
      port_b_rst_n = 1'b0;
      cyc(6);
    end

    // R4: new level adopted only after the window
    dual_sel_n = 1'b0;
    cyc(S / 2);
    chk("R4 not yet", lane_dual, 1'b0);
    cyc(S);
    chk("R4 adopted", lane_dual, 1'b1);

    // R10: two sync flops plus the output register
    port_a_rst_n = 1'b1;
    cyc(2);
    chk("R10 a_en after 2", port_a_en, 1'b0);
    cyc(1);
    chk("R10 a_en after 3", port_a_en, 1'b1);
    chk("R10 b held", port_b_en, 1'b0);

    // R7: select moves while locked
    dual_sel_n = 1'b1;
    cyc(6);
    chk("R7 fault", mode_fault, 1'b1);
    chk("R7 mode kept", lane_dual, 1'b1);

    // R8: fault survives a port reset cycle; R5 change legal while held
    port_a_rst_n = 1'b0;
    cyc(S + 6);
    chk("R8 sticky", mode_fault, 1'b1);
    chk("R5 change while held", lane_dual, 1'b0);

    // R6: early release
    rst_n = 1'b0;
    cyc(2);
    chk("R1 fault cleared", mode_fault, 1'b0);
    rst_n = 1'b1;
    cyc(S + 6);
    dual_sel_n = 1'b0;
    cyc(4);
    port_a_rst_n = 1'b1;
    cyc(6);
    chk("R6 fault", mode_fault, 1'b1);
    chk("R6 mode kept", lane_dual, 1'b0);
    chk("R6 a_en", port_a_en, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule